// File: doc/BRIEF.md
# Ethernet SQE Heartbeat Monitor

This block sits beside a 10 Mb/s MAC transmit path. It watches two signals: the transmit enable that the MAC drives to an external PHY, and the collision line that comes back from that PHY. After each frame, a healthy PHY answers with a short collision pulse called the signal-quality-error heartbeat. The monitor opens a timed window when transmit enable drops and looks for that pulse. It then records one of three outcomes: the heartbeat was present, the heartbeat was missing, or the pulse was too short. A collision that arrives while transmit enable is still high is a real in-frame collision. The monitor records it separately and never mistakes it for a heartbeat.

The block runs on the transmit clock that the PHY supplies (nominally 10 MHz). The window and the minimum pulse width are counted in clocks of that clock. By default the window is 16 clocks (1.6 µs) and the minimum width is 5 clocks (0.5 µs). All four outcomes are sticky flags. Software clears each flag by pulsing the matching bit of a write-one-to-clear input. An interrupt line stays high while any error flag is set. A new frame, seen as transmit enable going high, rearms the monitor and abandons any window that is still open.

Top module: `sqe_heartbeat_mon`

## Requirements
- R1: After reset, status is 4'b0000 and irq is 0. Status bit positions are: bit 0 heartbeat-present, bit 1 heartbeat-missing, bit 2 pulse-too-short, bit 3 in-frame collision.
- R2: Any clock edge that samples tx_en and col both high sets status bit 3 from the next cycle. Such a collision never sets bits 0, 1 or 2 by itself.
- R3: The window opens at the first edge that samples tx_en low after a frame. A collision rise (col sampled high after being sampled low) counts if it is seen within the next WIN_CLKS edges. If col is then sampled high on MIN_W consecutive edges, starting with the rise, bit 0 is set.
- R4: If no collision rise is seen within the window, bit 1 is set at the WIN_CLKS-th edge after the window opens, and not earlier. A pulse that rises after that edge is ignored.
- R5: If a collision rises inside the window but is sampled low before MIN_W high samples, bit 2 is set and bit 0 is not.
- R6: If tx_en rises while a window or pulse measurement is in progress, that measurement is abandoned and no outcome flag is set for it.
- R7: Driving clr bit i high for one cycle clears status bit i and leaves the other bits unchanged.
- R8: irq is high exactly when at least one of status bits 1, 2 or 3 is set. Bit 0 alone does not raise it.
- R9: A collision that is already high when the window opens does not count as a heartbeat unless it falls and rises again inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the PHY |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable as driven toward the PHY |
| col | input | 1 | Collision indication from the PHY |
| clr | input | 4 | Write-one-to-clear pulses, one per status bit |
| status | output | 4 | Sticky outcome flags (bit map in R1) |
| irq | output | 1 | High while any error flag is set |

## Verification
Two cases are the hardest to set up from the ports: the exact edge at which the window closes, and a collision that is already high when the window opens. The bench drives the pulse at both sides of the window boundary, once on the last accepted edge and once one edge late. It checks that the missing flag is still clear one cycle before the closing edge and set right after it. For R9, the bench holds col high across the fall of tx_en and for the whole window. It then checks that only the missing flag and the in-frame flag come up.

// File: rtl/sqe_heartbeat_mon.sv
module sqe_heartbeat_mon #(
  parameter int WIN_CLKS = 16,
  parameter int MIN_W    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       col,
  input  logic [3:0] clr,
  output logic [3:0] status,
  output logic       irq
);
  localparam int CW = $clog2(WIN_CLKS + 1);
  localparam int WW = $clog2(MIN_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_WIN, S_PULSE} st_t;

  st_t           st;
  logic          col_q;
  logic [CW-1:0] wcnt;
  logic [WW-1:0] pcnt;

  wire col_rise  = col & ~col_q;
  wire win_last  = (wcnt == CW'(WIN_CLKS - 1));
  wire set_ok    = (st == S_PULSE) && !tx_en && col && (pcnt == WW'(MIN_W - 1));
  wire set_short = (st == S_PULSE) && !tx_en && !col;
  wire set_miss  = (st == S_WIN) && !tx_en && !col_rise && win_last;
  wire set_inc   = tx_en & col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      col_q <= 1'b0;
      wcnt  <= '0;
      pcnt  <= '0;
    end else begin
      col_q <= col;
      if (tx_en) begin
        st <= S_FRAME;
      end else begin
        case (st)
          S_FRAME: begin
            st   <= S_WIN;
            wcnt <= '0;
          end
          S_WIN: begin
            if (col_rise) begin
              st   <= S_PULSE;
              pcnt <= WW'(1);
            end else if (win_last) begin
              st <= S_IDLE;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
          S_PULSE: begin
            if (!col || pcnt == WW'(MIN_W - 1)) st <= S_IDLE;
            else pcnt <= pcnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= {set_inc, set_short, set_miss, set_ok} | (status & ~clr);
  end

  assign irq = |status[3:1];

  p_incol_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && col) |=> status[3]);

  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_ok, set_miss, set_short}));

  p_win_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WIN) |-> (wcnt < CW'(WIN_CLKS)));

  p_ok_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> !$past(tx_en));

  p_clear_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[1] && !set_miss) |=> !status[1]);
endmodule

// File: tb/sqe_heartbeat_mon_tb.sv
module sqe_heartbeat_mon_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       col = 1'b0;
  logic [3:0] clr = 4'b0;
  logic [3:0] status;
  logic       irq;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sqe_heartbeat_mon dut_i (.clk(clk), .rst_n(rst_n), .tx_en(tx_en), .col(col),
                           .clr(clr), .status(status), .irq(irq));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk); clr = 4'hF;
    @(negedge clk); clr = 4'h0;
  endtask

  // frame of len cycles, pulse starts d negedges after tx_en low, w cycles wide
  task automatic frame_pulse(input int len, input int d, input int w);
    @(negedge clk); tx_en = 1'b1;
    wait_n(len);
    tx_en = 1'b0;
    if (w > 0) begin
      wait_n(d); col = 1'b1;
      wait_n(w); col = 1'b0;
    end
    wait_n(24);
  endtask

  task automatic t_reset();
    chk("R1 status", status, 4'b0000);
    chk("R1 irq", {3'b0, irq}, 4'b0000);
  endtask

  task automatic t_good();
    clear_all();
    frame_pulse(6, 1, 5);
    chk("R3 early minimal pulse", status, 4'b0001);
    chk("R8 ok alone no irq", {3'b0, irq}, 4'b0000);
    clear_all();
    frame_pulse(6, 16, 8);
    chk("R3 pulse on last window edge", status, 4'b0001);
  endtask

  task automatic t_missing();
    clear_all();
    @(negedge clk); tx_en = 1'b1;
    wait_n(5); tx_en = 1'b0;
    wait_n(16);
    chk("R4 not before window end", status, 4'b0000);
    wait_n(1);
    chk("R4 set at window end", status, 4'b0010);
    col = 1'b1; wait_n(6); col = 1'b0; wait_n(4);
    chk("R4 late pulse ignored", status, 4'b0010);
    chk("R8 missing raises irq", {3'b0, irq}, 4'b0001);
    clear_all();
    frame_pulse(6, 17, 6);
    chk("R4 pulse one edge late", status, 4'b0010);
  endtask

  task automatic t_short();
    clear_all();
    frame_pulse(6, 3, 4);
    chk("R5 width one short", status, 4'b0100);
    clear_all();
    frame_pulse(6, 2, 1);
    chk("R5 single-cycle pulse", status, 4'b0100);
    chk("R8 short raises irq", {3'b0, irq}, 4'b0001);
  endtask

  task automatic t_incol();
    clear_all();
    @(negedge clk); tx_en = 1'b1;
    wait_n(3); col = 1'b1;
    wait_n(3); col = 1'b0;
    wait_n(2);
    chk("R2 in-frame flag mid frame", status, 4'b1000);
    tx_en = 1'b0; wait_n(2); col = 1'b1; wait_n(5); col = 1'b0; wait_n(20);
    chk("R2 in-frame plus separate heartbeat", status, 4'b1001);
  endtask

  task automatic t_rearm();
    clear_all();
    @(negedge clk); tx_en = 1'b1;
    wait_n(4); tx_en = 1'b0;
    wait_n(3); tx_en = 1'b1;
    wait_n(25);
    chk("R6 abandoned window sets nothing", status, 4'b0000);
    tx_en = 1'b0; wait_n(2); col = 1'b1; wait_n(2);
    tx_en = 1'b1; col = 1'b0; wait_n(25);
    chk("R6 abandoned pulse sets nothing", status, 4'b0000);
    tx_en = 1'b0; wait_n(4); col = 1'b1; wait_n(5); col = 1'b0; wait_n(20);
    chk("R6 next window works", status, 4'b0001);
  endtask

  task automatic t_w1c();
    clear_all();
    frame_pulse(6, 3, 2);
    frame_pulse(6, 3, 6);
    chk("R7 two flags set", status, 4'b0101);
    @(negedge clk); clr = 4'b0001;
    @(negedge clk); clr = 4'b0000;
    chk("R7 clear bit0 only", status, 4'b0100);
    @(negedge clk); clr = 4'b0100;
    @(negedge clk); clr = 4'b0000;
    chk("R7 clear bit2", status, 4'b0000);
    chk("R8 irq drops after clear", {3'b0, irq}, 4'b0000);
  endtask

  task automatic t_held_col();
    clear_all();
    @(negedge clk); tx_en = 1'b1;
    wait_n(3); col = 1'b1;
    wait_n(3); tx_en = 1'b0;
    wait_n(22); col = 1'b0;
    wait_n(3);
    chk("R9 held collision not heartbeat", status, 4'b1010);
    clear_all();
    @(negedge clk); tx_en = 1'b1;
    wait_n(3); col = 1'b1;
    wait_n(3); tx_en = 1'b0;
    wait_n(2); col = 1'b0;
    wait_n(2); col = 1'b1;
    wait_n(5); col = 1'b0;
    wait_n(20);
    chk("R9 fall then rise counts", status, 4'b1001);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_good();
    t_missing();
    t_short();
    t_incol();
    t_rearm();
    t_w1c();
    t_held_col();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule